// File: doc/BRIEF.md
# Moving Window Deconvolution Unit

This block turns a stream of 16-bit unsigned, already decimated detector samples into a deconvolved signal. The preamplifier's exponential decay is removed from that signal. For every accepted sample x[n] it forms two quantities from one circular delay memory of 256 entries:

- the window difference D[n] = x[n] - x[n-M];
- the running sum S[n] of the last M samples.

The running sum goes through a pipelined 24x24 multiplier with a programmable unsigned fractional decay coefficient. The difference is held back by the same number of cycles. Fixed bit-field alignment joins the two terms into one signed 17.7 fixed-point result per sample.

After reset a small sequencer first writes zero into every memory location. This is state CLEAR, which moves to ARM once the last address is written. In ARM the accumulator is held at zero and the window length is captured. After one cycle the sequencer moves to RUN and stays there until the next reset. Samples are taken only in RUN, which is shown on `rdy`. The window length input is a constant setting; the coefficient is taken together with each sample.

Top module: `mwd_unit`

## Requirements
- R1: While reset is held, `rdy` and `res_vld` are 0. After reset is released, `rdy` rises after exactly 257 rising clock edges (256 in CLEAR, 1 in ARM) and then stays 1 until the next reset.
- R2: A reset wipes all sample history. Results after a reset match a history of all-zero samples, whatever was streamed before.
- R3: The difference term is D[n] = x[n] - x[n-M] as a 17-bit two's complement value, placed in result bits 23..7 with bits 6..0 zero. With coefficient 0 the result equals D[n] * 128.
- R4: The result is the 24-bit wrapping sum of the aligned difference and the aligned product. The aligned product has bit 23 = 0 and bits 22..0 = bits 38..16 of the 48-bit product S[n] * coef. S[n] is the unsigned sum of x[n-M+1] through x[n].
- R5: Every sample accepted (`smp_vld`=1 while `rdy`=1 at a rising edge) gives exactly one result, in order. `res_vld` is 1 for one cycle, 6 rising edges after the accepting edge.
- R6: A window code of 0 selects a window of 256 samples. Codes 1 to 255 select that many samples.
- R7: The window code is captured in the cycle before `rdy` rises. Changes to `win_len` while `rdy` is 1 have no effect on results.
- R8: Samples presented while `rdy` is 0 produce no result and do not enter the history.
- R9: The coefficient is taken in the same cycle as its sample, so it may change from one sample to the next.
- R10: Idle cycles (`smp_vld`=0) between samples do not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts memory clearing |
| smp_vld | input | 1 | Sample strobe |
| smp_dat | input | 16 | Unsigned decimated sample |
| win_len | input | 8 | Window length M (0 means 256) |
| coef | input | 24 | Unsigned decay coefficient, fraction scaled by 2^24 |
| rdy | output | 1 | High in RUN; samples are accepted only then |
| res_vld | output | 1 | Result strobe |
| res_dat | output | 24 | Signed 17.7 deconvolved result |

## Verification
The hardest case to reach is the full 256-sample window. Here the read address equals the write address, so the memory must return the old word before it is overwritten. The running sum also climbs to its 24-bit ceiling. The bench reaches this case by choosing window code 0 and streaming more than 256 full-scale samples with the largest coefficient, then dropping to zero so the old samples leave the window. A second awkward case is traffic during memory clearing. The bench drives samples from the first cycle after reset, then shows that no result appears and that later results still see zero history.

// File: rtl/mwd_pkg.sv
package mwd_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_ARM   = 2'd1,
        ST_RUN   = 2'd2
    } mwd_state_e;

endpackage

// File: rtl/mwd_ctrl.sv
module mwd_ctrl #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] win_len,
    output logic          clr_we,
    output logic [AW-1:0] clr_addr,
    output logic          run,
    output logic [AW-1:0] win_q
);
    import mwd_pkg::*;

    localparam logic [AW-1:0] LAST_ADDR = {AW{1'b1}};

    mwd_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (clr_addr == LAST_ADDR) state_d = ST_ARM;
            ST_ARM:   state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_CLEAR;
        endcase
    end

    // state outputs
    always_comb begin
        clr_we = 1'b0;
        run    = 1'b0;
        unique case (state_q)
            ST_CLEAR: clr_we = 1'b1;
            ST_ARM:   ;
            ST_RUN:   run = 1'b1;
            default:  ;
        endcase
    end

    // clear address walk and window capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_addr <= '0;
            win_q    <= '0;
        end else begin
            if (state_q == ST_CLEAR) clr_addr <= clr_addr + 1'b1;
            if (state_q == ST_ARM)   win_q    <= win_len;
        end
    end

    a_r1_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> run);

    a_r1_arm_after_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM) |-> ($past(clr_addr) == LAST_ADDR));

    a_r7_window_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(win_q));

endmodule

// File: rtl/mwd_delay_line.sv
module mwd_delay_line #(
    parameter int DW = 16,
    parameter int AW = 8,
    parameter int CW = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_we,
    input  logic [AW-1:0]    clr_addr,
    input  logic             run,
    input  logic             smp_vld,
    input  logic [DW-1:0]    smp_dat,
    input  logic [AW-1:0]    win,
    input  logic [CW-1:0]    coef,
    output logic             vld_q,
    output logic [DW:0]      diff_q,
    output logic [DW+AW-1:0] sum_q,
    output logic [CW-1:0]    coef_q
);
    localparam int DEPTH = 1 << AW;
    localparam int SW    = DW + AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [DW-1:0] old_smp;
    logic          take;

    assign take    = run & smp_vld;
    // a window code of 0 reads the slot about to be overwritten: 256 back
    assign rd_ptr  = wr_ptr - win;
    assign old_smp = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (clr_we) begin
            mem[clr_addr] <= '0;
        end else if (take) begin
            mem[wr_ptr] <= smp_dat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            vld_q  <= 1'b0;
            diff_q <= '0;
            sum_q  <= '0;
            coef_q <= '0;
        end else begin
            vld_q <= take;
            if (!run) begin
                sum_q <= '0;
            end else if (take) begin
                diff_q <= {1'b0, smp_dat} - {1'b0, old_smp};
                sum_q  <= sum_q + SW'(smp_dat) - SW'(old_smp);
                coef_q <= coef;
                wr_ptr <= wr_ptr + 1'b1;
            end
        end
    end

    a_r8_idle_takes_nothing: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !vld_q);

    a_r10_gap_holds_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !smp_vld) |=> ($stable(sum_q) && $stable(wr_ptr)));

    a_r5_pointer_step: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (wr_ptr == AW'($past(wr_ptr) + 1'b1)));

endmodule

// File: rtl/mwd_mult.sv
module mwd_mult #(
    parameter int AWID = 24,
    parameter int BWID = 24,
    parameter int LAT  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic [AWID-1:0]      a,
    input  logic [BWID-1:0]      b,
    output logic                 out_vld,
    output logic [AWID+BWID-1:0] prod
);
    localparam int PW  = AWID + BWID;
    localparam int NPS = LAT - 1;

    logic [AWID-1:0] a_r;
    logic [BWID-1:0] b_r;
    logic            v_r;
    logic [PW-1:0]   p_pipe [NPS];
    logic            v_pipe [NPS];

    generate
        if (LAT < 2) begin : g_bad_lat
            initial $error("mwd_mult needs LAT >= 2");
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_r <= '0;
            b_r <= '0;
            v_r <= 1'b0;
            for (int k = 0; k < NPS; k++) begin
                p_pipe[k] <= '0;
                v_pipe[k] <= 1'b0;
            end
        end else begin
            a_r       <= a;
            b_r       <= b;
            v_r       <= in_vld;
            p_pipe[0] <= PW'(a_r) * PW'(b_r);
            v_pipe[0] <= v_r;
            for (int k = 1; k < NPS; k++) begin
                p_pipe[k] <= p_pipe[k-1];
                v_pipe[k] <= v_pipe[k-1];
            end
        end
    end

    assign prod    = p_pipe[NPS-1];
    assign out_vld = v_pipe[NPS-1];

    a_r4_zero_coef_zero_product: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && $past(v_r, NPS) && ($past(b_r, NPS) == '0)) |-> (prod == '0));

endmodule

// File: rtl/mwd_align.sv
module mwd_align #(
    parameter int DFW    = 17,
    parameter int FRAC   = 7,
    parameter int SEL_LO = 16,
    parameter int PW     = 48,
    parameter int LAT    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DFW-1:0]      diff_in,
    input  logic                prod_vld,
    input  logic [PW-1:0]       prod,
    output logic                res_vld,
    output logic [DFW+FRAC-1:0] res_dat
);
    localparam int RW     = DFW + FRAC;
    localparam int SEL_HI = SEL_LO + RW - 2;

    logic [DFW-1:0] d_pipe [LAT];
    logic [RW-1:0]  diff_al;
    logic [RW-1:0]  prod_al;
    logic           unused_prod_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < LAT; k++) d_pipe[k] <= '0;
        end else begin
            d_pipe[0] <= diff_in;
            for (int k = 1; k < LAT; k++) d_pipe[k] <= d_pipe[k-1];
        end
    end

    assign diff_al = {d_pipe[LAT-1], {FRAC{1'b0}}};
    assign prod_al = {1'b0, prod[SEL_HI:SEL_LO]};
    assign unused_prod_bits = ^{prod[PW-1:SEL_HI+1], prod[SEL_LO-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_vld <= 1'b0;
            res_dat <= '0;
        end else begin
            res_vld <= prod_vld;
            if (prod_vld) res_dat <= diff_al + prod_al;
        end
    end

    a_r5_single_pulse_per_product: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !$past(prod_vld)) |-> 1'b0);

endmodule

// File: rtl/mwd_unit.sv
module mwd_unit #(
    parameter int DW      = 16,
    parameter int AW      = 8,
    parameter int CW      = 24,
    parameter int MUL_LAT = 4,
    parameter int FRAC    = 7,
    parameter int SEL_LO  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_vld,
    input  logic [DW-1:0]        smp_dat,
    input  logic [AW-1:0]        win_len,
    input  logic [CW-1:0]        coef,
    output logic                 rdy,
    output logic                 res_vld,
    output logic [DW+FRAC:0]     res_dat
);
    localparam int SW  = DW + AW;
    localparam int DFW = DW + 1;
    localparam int PW  = SW + CW;

    logic          clr_we;
    logic [AW-1:0] clr_addr;
    logic          run;
    logic [AW-1:0] win_q;
    logic          dl_vld;
    logic [DFW-1:0] dl_diff;
    logic [SW-1:0] dl_sum;
    logic [CW-1:0] dl_coef;
    logic          mul_vld;
    logic [PW-1:0] mul_prod;

    mwd_ctrl #(.AW(AW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_len  (win_len),
        .clr_we   (clr_we),
        .clr_addr (clr_addr),
        .run      (run),
        .win_q    (win_q)
    );

    mwd_delay_line #(.DW(DW), .AW(AW), .CW(CW)) u_dline (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_we   (clr_we),
        .clr_addr (clr_addr),
        .run      (run),
        .smp_vld  (smp_vld),
        .smp_dat  (smp_dat),
        .win      (win_q),
        .coef     (coef),
        .vld_q    (dl_vld),
        .diff_q   (dl_diff),
        .sum_q    (dl_sum),
        .coef_q   (dl_coef)
    );

    mwd_mult #(.AWID(SW), .BWID(CW), .LAT(MUL_LAT)) u_mult (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (dl_vld),
        .a       (dl_sum),
        .b       (dl_coef),
        .out_vld (mul_vld),
        .prod    (mul_prod)
    );

    mwd_align #(.DFW(DFW), .FRAC(FRAC), .SEL_LO(SEL_LO), .PW(PW), .LAT(MUL_LAT)) u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .diff_in  (dl_diff),
        .prod_vld (mul_vld),
        .prod     (mul_prod),
        .res_vld  (res_vld),
        .res_dat  (res_dat)
    );

    assign rdy = run;

    a_r5_result_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
        $past(smp_vld && rdy, MUL_LAT + 2) |-> res_vld);

    a_r5_no_result_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(smp_vld && rdy, MUL_LAT + 2));

    a_r8_no_result_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && !$past(rdy)) |-> !res_vld);

endmodule

// File: tb/mwd_unit_bench.sv
`timescale 1ns/1ps
module mwd_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [15:0] smp_dat = '0;
    logic [7:0]  win_len = 8'd4;
    logic [23:0] coef = '0;
    logic        rdy;
    logic        res_vld;
    logic [23:0] res_dat;

    int n_chk = 0;
    int n_bad = 0;
    int m_win = 4;
    int hist[$];
    logic [23:0] got[$];
    logic [23:0] exp_q[$];

    always #2.5 clk = ~clk;

    mwd_unit u_mwd_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_vld (smp_vld),
        .smp_dat (smp_dat),
        .win_len (win_len),
        .coef    (coef),
        .rdy     (rdy),
        .res_vld (res_vld),
        .res_dat (res_dat)
    );

    always @(negedge clk) begin
        if (rst_n && res_vld) got.push_back(res_dat);
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        summary();
        $finish;
    end

    task automatic chk(string req, longint act, longint expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [23:0] model_step(int x, int c);
        int n;
        int old;
        int first;
        longint sum;
        logic [16:0] d17;
        logic [47:0] p;
        hist.push_back(x);
        n = hist.size();
        old = (n > m_win) ? hist[n-1-m_win] : 0;
        first = (n > m_win) ? n - m_win : 0;
        sum = 0;
        for (int k = first; k < n; k++) sum += hist[k];
        d17 = 17'(x - old);
        p = 48'(sum) * 48'(c);
        return {d17, 7'b0} + {1'b0, p[38:16]};
    endfunction

    task automatic wait_ready();
        int guard = 0;
        while (!rdy && guard < 400) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic do_reset(int w);
        smp_vld = 1'b0;
        win_len = 8'(w);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        hist.delete();
        got.delete();
        exp_q.delete();
        m_win = (w == 0) ? 256 : w;
        rst_n = 1'b1;
        @(negedge clk);
        wait_ready();
    endtask

    task automatic send(int x, int c);
        smp_vld = 1'b1;
        smp_dat = 16'(x);
        coef = 24'(c);
        exp_q.push_back(model_step(x, c));
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic drain(string req);
        int n;
        repeat (10) @(negedge clk);
        chk({req, " result count"}, got.size(), exp_q.size());
        n = (got.size() < exp_q.size()) ? got.size() : exp_q.size();
        for (int k = 0; k < n; k++) chk(req, got[k], exp_q[k]);
        got.delete();
        exp_q.delete();
    endtask

    // R1: reset state and start-up length
    task automatic t_reset();
        int cnt = 0;
        smp_vld = 1'b0;
        win_len = 8'd4;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 rdy in reset", rdy, 0);
        chk("R1 res_vld in reset", res_vld, 0);
        rst_n = 1'b1;
        while (!rdy && cnt < 1000) begin
            @(negedge clk);
            cnt++;
        end
        chk("R1 edges to rdy", cnt, 257);
        repeat (20) @(negedge clk);
        chk("R1 rdy stays high", rdy, 1);
    endtask

    // R8: traffic during clearing is dropped
    task automatic t_early();
        smp_vld = 1'b0;
        win_len = 8'd4;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        hist.delete();
        got.delete();
        exp_q.delete();
        m_win = 4;
        rst_n = 1'b1;
        smp_vld = 1'b1;
        smp_dat = 16'hFFFF;
        coef = 24'h00FFFF;
        while (!rdy) @(negedge clk);
        smp_vld = 1'b0;
        repeat (10) @(negedge clk);
        chk("R8 no result before rdy", got.size(), 0);
        for (int k = 0; k < 8; k++) send(1000 + 37 * k, 24'h00FFFF);
        drain("R8 zero history after dropped samples");
    endtask

    // R3: difference term with zero coefficient
    task automatic t_diff();
        do_reset(4);
        for (int k = 0; k < 10; k++) send(500 * k, 0);
        for (int k = 0; k < 10; k++) send(60000 - 6000 * k, 0);
        drain("R3 difference only");
    endtask

    // R4: full combination with a nonzero coefficient
    task automatic t_full();
        int lcg = 12345;
        do_reset(16);
        for (int k = 0; k < 60; k++) begin
            lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            send((lcg >> 8) & 16'hFFFF, 24'h03C17B);
        end
        drain("R4 sum scaled and added");
    endtask

    // R5: latency and one result per sample
    task automatic t_lat();
        int cnt = 0;
        do_reset(8);
        smp_vld = 1'b1;
        smp_dat = 16'd4321;
        coef = 24'h123456;
        exp_q.push_back(model_step(4321, 24'h123456));
        @(negedge clk);
        smp_vld = 1'b0;
        cnt = 1;
        while (!res_vld && cnt < 20) begin
            @(negedge clk);
            cnt++;
        end
        chk("R5 latency edges", cnt, 6);
        @(negedge clk);
        chk("R5 strobe one cycle", res_vld, 0);
        drain("R5 single result");
    endtask

    // R6: code 0 means a 256-sample window
    task automatic t_win256();
        do_reset(0);
        for (int k = 0; k < 270; k++) send(16'hFFFF, 24'hFFFFFF);
        for (int k = 0; k < 20; k++) send(0, 24'hFFFFFF);
        drain("R6 full window");
    endtask

    // R7: window change while running is ignored
    task automatic t_hold();
        do_reset(5);
        win_len = 8'd9;
        for (int k = 0; k < 20; k++) send(300 * k + 7, 24'h020000);
        drain("R7 window held");
    endtask

    // R9: coefficient follows its own sample
    task automatic t_coef();
        do_reset(3);
        for (int k = 0; k < 16; k++) send(2000 + 100 * k, (k % 2) ? 24'hABCDEF : 24'h000100);
        drain("R9 per-sample coefficient");
    endtask

    // R10: idle gaps between samples
    task automatic t_gaps();
        do_reset(6);
        for (int k = 0; k < 20; k++) begin
            send(777 * k, 24'h044000);
            repeat (k % 4) @(negedge clk);
        end
        drain("R10 gaps");
    endtask

    // R2: reset wipes history
    task automatic t_restart();
        do_reset(7);
        for (int k = 0; k < 20; k++) send(50000 - 1000 * k, 24'h100000);
        drain("R2 before reset");
        do_reset(7);
        for (int k = 0; k < 10; k++) send(10 * k, 24'h100000);
        drain("R2 after reset");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_early();
        t_diff();
        t_full();
        t_lat();
        t_win256();
        t_hold();
        t_coef();
        t_gaps();
        t_restart();
        summary();
        $finish;
    end

endmodule